// File: doc/BRIEF.md
# Message Object Transfer Unit with Dual Interface Register Sets

The block sits between a host register bus and an on-chip store of message objects. The host never touches the store directly. It works through two independent interface register sets. Each set holds a mask word, an arbitration word, a control word and a data field of `DATA_WORDS` words. The host fills a set, then writes that set's command register with an object number and a direction bit. A small transfer engine then copies the set into the addressed object, or copies the object back into the set. While a set's transfer is pending or running, that set reports busy and refuses new commands.

Every object carries four status bits in control bits [3:0]: bit 0 valid, bit 1 new data, bit 2 interrupt pending, bit 3 transmit request. They live in a separate status array. After reset the engine walks every object, one per clock, and zeroes those four bits. Mask, arbitration, the upper control bits and data are left as they were. A host-controlled init bit comes out of reset set. It holds the engine idle, and the engine starts serving queued commands once the host clears it.

Top module: `ifx_msg_xfer`

## Requirements
- R1: Bus map: `host_addr[4]` selects set 0 or set 1; `host_addr[3:0]` selects mask (0), arbitration (1), control (2), data words (3, 4), command (5) or the shared global register (15). A read returns the addressed word on `host_rdata` one clock after `host_rd`. All set registers and `host_rdata` are zero after reset.
- R2: A command write with bit 16 = 1 copies the set's mask, arbitration, control and data into the object numbered by command bits [3:0].
- R3: A command write with bit 16 = 0 copies the addressed object, including its four status bits, into the set's registers.
- R4: A set is busy from the clock after an accepted command until its transfer completes. Busy shows on `if_busy` and as bit 31 of the command register, which also returns the direction in bit 16 and the object number in bits [3:0]. A command write to a busy set is ignored.
- R5: When both sets have a command waiting, set 0 is served first; set 1 is served after it.
- R6: The init bit (global register bit 0) is 1 after reset. While it is 1, no transfer starts and commands stay queued. Writing 0 to it lets queued commands run.
- R7: Reset leaves mask, arbitration, control bits [31:4] and data of every object unchanged.
- R8: After reset, `sweep_busy` is high for exactly `NUM_OBJ` clocks while control bits [3:0] of every object are cleared. No transfer starts during the sweep.
- R9: Global register bit 1 reads the sweep-busy state; its other upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 5 | Set select (bit 4) and register index (bits 3:0) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| if_busy | output | 2 | Per-set busy flags |
| sweep_busy | output | 1 | High while the status sweep runs |

## Verification
The assertions check on every cycle that:
- at most one set is completed at a time;
- a command written to a busy set leaves that set's latched object and direction untouched;
- a waiting set 0 wins over a waiting set 1;
- the engine stays idle while init is set or the sweep runs, and the sweep ends after exactly `NUM_OBJ` steps.

Only the bench scenarios can show the data actually moved. They cover:
- object contents round-tripping through the opposite set;
- the survival of configuration across a reset while the status bits clear;
- the final object contents after competing queued writes.

// File: rtl/ifx_pkg.sv
package ifx_pkg;
  localparam int REG_W      = 32;
  localparam int DATA_WORDS = 2;
  localparam int ST_BITS    = 4;
  localparam int DATA_W     = REG_W * DATA_WORDS;
  localparam int IDX_W      = 4;
  localparam logic [IDX_W-1:0] IDX_MASK = 4'd0;
  localparam logic [IDX_W-1:0] IDX_ARB  = 4'd1;
  localparam logic [IDX_W-1:0] IDX_CTRL = 4'd2;
  localparam logic [IDX_W-1:0] IDX_DAT0 = 4'd3;
  localparam logic [IDX_W-1:0] IDX_CMD  = IDX_W'(3 + DATA_WORDS);
  localparam logic [IDX_W-1:0] IDX_GLB  = 4'd15;
  localparam int DIR_BIT  = 16;
  localparam int BUSY_BIT = 31;

  typedef struct packed {
    logic [REG_W-1:0]       mask;
    logic [REG_W-1:0]       arb;
    logic [REG_W-1:ST_BITS] ctrl_cfg;
    logic [DATA_W-1:0]      data;
  } cfg_t;

  typedef enum logic [1:0] {ENG_IDLE, ENG_XFER, ENG_CAPT} eng_st_e;
endpackage

// File: rtl/ifx_obj_ram.sv
module ifx_obj_ram
  import ifx_pkg::*;
#(
  parameter int NUM_OBJ = 16,
  localparam int OBJ_W = $clog2(NUM_OBJ)
) (
  input  logic               clk,
  input  logic               we_cfg,
  input  logic               we_st,
  input  logic [OBJ_W-1:0]   waddr,
  input  cfg_t               wcfg,
  input  logic [ST_BITS-1:0] wst,
  input  logic [OBJ_W-1:0]   raddr,
  output cfg_t               rcfg,
  output logic [ST_BITS-1:0] rst_bits
);
  cfg_t               cfg_mem [NUM_OBJ];
  logic [ST_BITS-1:0] st_mem  [NUM_OBJ];

  always_ff @(posedge clk) begin
    if (we_cfg) cfg_mem[waddr] <= wcfg;
    rcfg <= cfg_mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (we_st) st_mem[waddr] <= wst;
    rst_bits <= st_mem[raddr];
  end
endmodule

// File: rtl/ifx_regset.sv
module ifx_regset
  import ifx_pkg::*;
#(
  parameter int OBJ_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [REG_W-1:0]   wdata,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [REG_W-1:0]   rd_word,
  input  logic               done_i,
  input  logic               load_i,
  input  cfg_t               ld_cfg,
  input  logic [ST_BITS-1:0] ld_st,
  output logic               pend_o,
  output logic               dir_o,
  output logic [OBJ_W-1:0]   obj_o,
  output cfg_t               cfg_o,
  output logic [ST_BITS-1:0] st_o
);
  logic [REG_W-1:0]  mask_q, arb_q, ctrl_q;
  logic [DATA_W-1:0] data_q;
  logic              pend_q, dir_q;
  logic [OBJ_W-1:0]  obj_q;
  logic              cmd_wr;

  assign cmd_wr = wr_en && (wr_idx == IDX_CMD);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      arb_q  <= '0;
      ctrl_q <= '0;
      data_q <= '0;
      pend_q <= 1'b0;
      dir_q  <= 1'b0;
      obj_q  <= '0;
    end else begin
      if (load_i) begin
        mask_q <= ld_cfg.mask;
        arb_q  <= ld_cfg.arb;
        ctrl_q <= {ld_cfg.ctrl_cfg, ld_st};
        data_q <= ld_cfg.data;
      end else if (wr_en) begin
        if (wr_idx == IDX_MASK) mask_q <= wdata;
        if (wr_idx == IDX_ARB)  arb_q  <= wdata;
        if (wr_idx == IDX_CTRL) ctrl_q <= wdata;
        for (int i = 0; i < DATA_WORDS; i++)
          if (wr_idx == IDX_W'(3 + i)) data_q[i*REG_W +: REG_W] <= wdata;
      end
      if (done_i) begin
        pend_q <= 1'b0;
      end else if (cmd_wr && !pend_q) begin
        pend_q <= 1'b1;
        dir_q  <= wdata[DIR_BIT];
        obj_q  <= wdata[OBJ_W-1:0];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (rd_idx == IDX_MASK) rd_word = mask_q;
    if (rd_idx == IDX_ARB)  rd_word = arb_q;
    if (rd_idx == IDX_CTRL) rd_word = ctrl_q;
    for (int i = 0; i < DATA_WORDS; i++)
      if (rd_idx == IDX_W'(3 + i)) rd_word = data_q[i*REG_W +: REG_W];
    if (rd_idx == IDX_CMD) begin
      rd_word[BUSY_BIT]  = pend_q;
      rd_word[DIR_BIT]   = dir_q;
      rd_word[OBJ_W-1:0] = obj_q;
    end
  end

  assign pend_o = pend_q;
  assign dir_o  = dir_q;
  assign obj_o  = obj_q;
  assign cfg_o  = '{mask: mask_q, arb: arb_q, ctrl_cfg: ctrl_q[REG_W-1:ST_BITS], data: data_q};
  assign st_o   = ctrl_q[ST_BITS-1:0];

  // R4
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && pend_q && !done_i) |=> (pend_q && $stable(obj_q) && $stable(dir_q)));
endmodule

// File: rtl/ifx_engine.sv
module ifx_engine
  import ifx_pkg::*;
#(
  parameter int NUM_OBJ = 16,
  localparam int OBJ_W = $clog2(NUM_OBJ)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         init,
  input  logic [1:0]                   pend,
  input  logic [1:0]                   dir,
  input  logic [1:0][OBJ_W-1:0]        obj,
  input  cfg_t [1:0]                   cfg_in,
  input  logic [1:0][ST_BITS-1:0]      st_in,
  output logic                         we_cfg,
  output logic                         we_st,
  output logic [OBJ_W-1:0]             waddr,
  output cfg_t                         wcfg,
  output logic [ST_BITS-1:0]           wst,
  output logic [OBJ_W-1:0]             raddr,
  output logic [1:0]                   done,
  output logic [1:0]                   load,
  output logic                         sweep_busy
);
  eng_st_e          st_q;
  logic             gsel_q, gdir_q;
  logic [OBJ_W-1:0] gobj_q;
  logic             sweep_q;
  logic [OBJ_W-1:0] swp_cnt_q;
  logic             go, gsel_d;

  assign go     = (st_q == ENG_IDLE) && !init && !sweep_q && (pend != 2'b00);
  assign gsel_d = ~pend[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ENG_IDLE;
      gsel_q    <= 1'b0;
      gdir_q    <= 1'b0;
      gobj_q    <= '0;
      sweep_q   <= 1'b1;
      swp_cnt_q <= '0;
    end else begin
      if (sweep_q) begin
        swp_cnt_q <= swp_cnt_q + 1'b1;
        if (swp_cnt_q == OBJ_W'(NUM_OBJ - 1)) sweep_q <= 1'b0;
      end
      case (st_q)
        ENG_IDLE: if (go) begin
          st_q   <= ENG_XFER;
          gsel_q <= gsel_d;
          gdir_q <= dir[gsel_d];
          gobj_q <= obj[gsel_d];
        end
        ENG_XFER: st_q <= gdir_q ? ENG_IDLE : ENG_CAPT;
        default:  st_q <= ENG_IDLE;
      endcase
    end
  end

  assign we_cfg = (st_q == ENG_XFER) && gdir_q;
  assign we_st  = we_cfg || sweep_q;
  assign waddr  = sweep_q ? swp_cnt_q : gobj_q;
  assign wcfg   = cfg_in[gsel_q];
  assign wst    = sweep_q ? '0 : st_in[gsel_q];
  assign raddr  = gobj_q;
  assign sweep_busy = sweep_q;

  always_comb begin
    done = 2'b00;
    load = 2'b00;
    if (we_cfg || st_q == ENG_CAPT) done[gsel_q] = 1'b1;
    if (st_q == ENG_CAPT)           load[gsel_q] = 1'b1;
  end

  // R4
  one_done_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(done));
  // R5
  set0_first_chk: assert property (@(posedge clk) disable iff (rst)
    (go && pend == 2'b11) |=> (st_q == ENG_XFER && !gsel_q));
  // R6
  init_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ENG_IDLE && init) |=> (st_q == ENG_IDLE));
  // R8
  sweep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    sweep_q |-> (!we_cfg && st_q == ENG_IDLE));
  // R8
  sweep_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sweep_q) |-> ($past(swp_cnt_q) == OBJ_W'(NUM_OBJ - 1)));
endmodule

// File: rtl/ifx_msg_xfer.sv
module ifx_msg_xfer
  import ifx_pkg::*;
#(
  parameter int NUM_OBJ = 16,
  localparam int OBJ_W = $clog2(NUM_OBJ)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [4:0]       host_addr,
  input  logic [REG_W-1:0] host_wdata,
  output logic [REG_W-1:0] host_rdata,
  output logic [1:0]       if_busy,
  output logic             sweep_busy
);
  logic                    init_q;
  logic [REG_W-1:0]        rdata_q;
  logic [IDX_W-1:0]        idx;
  logic [1:0][REG_W-1:0]   rd_word;
  logic [1:0]              pend, dir, done, load;
  logic [1:0][OBJ_W-1:0]   obj;
  cfg_t [1:0]              cfg_set;
  logic [1:0][ST_BITS-1:0] st_set;
  logic                    we_cfg, we_st;
  logic [OBJ_W-1:0]        waddr, raddr;
  cfg_t                    wcfg, rcfg;
  logic [ST_BITS-1:0]      wst, rstat;
  logic                    glb_sel;

  assign idx     = host_addr[IDX_W-1:0];
  assign glb_sel = (idx == IDX_GLB);

  for (genvar s = 0; s < 2; s++) begin : g_set
    ifx_regset #(.OBJ_W(OBJ_W)) i_set (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (host_wr && !glb_sel && (host_addr[4] == 1'(s))),
      .wr_idx (idx),
      .wdata  (host_wdata),
      .rd_idx (idx),
      .rd_word(rd_word[s]),
      .done_i (done[s]),
      .load_i (load[s]),
      .ld_cfg (rcfg),
      .ld_st  (rstat),
      .pend_o (pend[s]),
      .dir_o  (dir[s]),
      .obj_o  (obj[s]),
      .cfg_o  (cfg_set[s]),
      .st_o   (st_set[s])
    );
  end

  ifx_engine #(.NUM_OBJ(NUM_OBJ)) i_eng (
    .clk       (clk),
    .rst       (rst),
    .init      (init_q),
    .pend      (pend),
    .dir       (dir),
    .obj       (obj),
    .cfg_in    (cfg_set),
    .st_in     (st_set),
    .we_cfg    (we_cfg),
    .we_st     (we_st),
    .waddr     (waddr),
    .wcfg      (wcfg),
    .wst       (wst),
    .raddr     (raddr),
    .done      (done),
    .load      (load),
    .sweep_busy(sweep_busy)
  );

  ifx_obj_ram #(.NUM_OBJ(NUM_OBJ)) i_ram (
    .clk     (clk),
    .we_cfg  (we_cfg),
    .we_st   (we_st),
    .waddr   (waddr),
    .wcfg    (wcfg),
    .wst     (wst),
    .raddr   (raddr),
    .rcfg    (rcfg),
    .rst_bits(rstat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q  <= 1'b1;
      rdata_q <= '0;
    end else begin
      if (host_wr && glb_sel) init_q <= host_wdata[0];
      if (host_rd)
        rdata_q <= glb_sel ? {{(REG_W-2){1'b0}}, sweep_busy, init_q}
                           : rd_word[host_addr[4]];
    end
  end

  assign host_rdata = rdata_q;
  assign if_busy    = pend;

  // R1
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> $stable(host_rdata));
endmodule

// File: tb/test_ifx_msg_xfer.sv
module test_ifx_msg_xfer;
  localparam int NOBJ = 16;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [4:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic [1:0]  if_busy;
  logic        sweep_busy;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  ifx_msg_xfer #(.NUM_OBJ(NOBJ)) i_ifx_msg_xfer (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .if_busy(if_busy), .sweep_busy(sweep_busy)
  );

  function automatic logic [31:0] pat(int o, int f, int g);
    logic [31:0] v;
    v = (32'h9E37_79B9 * 32'(o + 1)) ^ (32'h1111_0000 * 32'(f + 1)) ^ (32'h0000_0707 * 32'(g));
    if (f == 2) v = v | 32'hF;
    return v;
  endfunction

  function automatic int gen_of(int o);
    if (o == 5) return 1;
    if (o == 9) return 3;
    return 0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Caller is at a negedge; returns at the next negedge.
  task automatic hw(int s, int idx, logic [31:0] d);
    host_wr = 1'b1; host_addr = {1'(s), 4'(idx)}; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hr(int s, int idx, output logic [31:0] d);
    host_rd = 1'b1; host_addr = {1'(s), 4'(idx)};
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic wait_idle();
    while (if_busy != 2'b00) @(negedge clk);
  endtask

  task automatic fill(int s, int o, int g);
    for (int f = 0; f < 5; f++) hw(s, f, pat(o, f, g));
  endtask

  task automatic count_sweep(output int c);
    c = 0;
    while (sweep_busy) begin c++; @(negedge clk); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int c;
    logic saw10, saw01;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8 sweep length after reset
    count_sweep(c);
    check("R8 sweep cycles", 32'(c), 32'(NOBJ));
    check("R1 reset rdata", host_rdata, 32'h0);
    // R6/R9 init set after reset, sweep done
    hr(0, 15, d); check("R6 R9 global after reset", d, 32'h1);
    for (int s = 0; s < 2; s++)
      for (int f = 0; f < 6; f++) begin
        hr(s, f, d); check("R1 reset register", d, 32'h0);
      end
    // R6: queued while init
    fill(0, 0, 0);
    hw(0, 5, 32'h0001_0000);
    repeat (20) @(negedge clk);
    check("R6 held while init", {30'b0, if_busy}, 32'h1);
    hw(0, 15, 32'h0);
    wait_idle();
    check("R6 runs after init cleared", {30'b0, if_busy}, 32'h0);
    // R2: write every object from alternating sets
    for (int o = 0; o < NOBJ; o++) begin
      fill(o % 2, o, 0);
      hw(o % 2, 5, 32'h0001_0000 | 32'(o));
      if (o == 3) begin
        hr(1, 5, d); check("R4 command reg while busy", d, 32'h8001_0003);
      end
      wait_idle();
    end
    hr(1, 5, d); check("R4 command reg idle", d, 32'h0001_0000 | 32'(NOBJ - 1));
    // R3: read every object through the other set
    for (int o = 0; o < NOBJ; o++) begin
      hw(1 - (o % 2), 5, 32'(o));
      wait_idle();
      for (int f = 0; f < 5; f++) begin
        hr(1 - (o % 2), f, d); check("R2 R3 round trip", d, pat(o, f, 0));
      end
    end
    // R4: back-to-back command, second ignored
    fill(0, 5, 1);
    hw(0, 5, 32'h0001_0005);
    hw(0, 5, 32'h0001_0006);
    check("R4 busy after command", {30'b0, if_busy}, 32'h1);
    wait_idle();
    hr(0, 5, d); check("R4 latched command kept", d, 32'h0001_0005);
    hw(1, 5, 32'h6); wait_idle();
    hr(1, 0, d); check("R4 ignored command left object", d, pat(6, 0, 0));
    hw(1, 5, 32'h5); wait_idle();
    hr(1, 0, d); check("R2 accepted command wrote object", d, pat(5, 0, 1));
    // R5: both queued under init, then released
    hw(0, 15, 32'h1);
    fill(0, 9, 2); hw(0, 5, 32'h0001_0009);
    fill(1, 9, 3); hw(1, 5, 32'h0001_0009);
    repeat (5) @(negedge clk);
    check("R6 both held", {30'b0, if_busy}, 32'h3);
    hw(0, 15, 32'h0);
    saw10 = 1'b0; saw01 = 1'b0;
    while (if_busy != 2'b00) begin
      if (if_busy == 2'b10) saw10 = 1'b1;
      if (if_busy == 2'b01) saw01 = 1'b1;
      @(negedge clk);
    end
    check("R5 set 0 finished first", {30'b0, saw01, saw10}, 32'h1);
    hw(0, 5, 32'h9); wait_idle();
    for (int f = 0; f < 5; f++) begin
      hr(0, f, d); check("R5 later set wins object", d, pat(9, f, 3));
    end
    // R7/R8: reset keeps configuration, clears status
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    hr(0, 15, d); check("R9 global shows sweep", d, 32'h3);
    count_sweep(c);
    check("R8 sweep cycles second reset", 32'(c + 1), 32'(NOBJ));
    hr(0, 15, d); check("R6 init set again", d, 32'h1);
    hw(0, 15, 32'h0);
    for (int o = 0; o < NOBJ; o++) begin
      hw(0, 5, 32'(o)); wait_idle();
      for (int f = 0; f < 5; f++) begin
        hr(0, f, d);
        if (f == 2) check("R8 status cleared, R7 ctrl kept", d, pat(o, 2, gen_of(o)) & 32'hFFFF_FFF0);
        else        check("R7 config kept", d, pat(o, f, gen_of(o)));
      end
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule